// File: doc/BRIEF.md
# Circular LIFO Line-Buffer Entry Allocator

This block keeps the bookkeeping for a small pool of line-buffer entries that software claims around loops. The pool is handled as a last-in first-out stack laid over a ring: a top pointer marks the next free slot, an acquire command claims one slot (or two when the extra-line flag is raised), and a release command gives back a counted number of slots and marks them invalid. When more slots are claimed than exist, the pointer wraps and the oldest claims are reused without any error.

Each memory access that targets the pool carries a small offset. The block turns that offset into a physical entry number relative to the current top and says whether the entry is live. If it is not, the access is told to go to the ordinary data cache instead. When an acquire reuses an entry that is still live and holds modified data, the block names that entry so its modified bytes can be written back before the new line is filled. A flush input drops every claim at once, for example on a context switch. Line data, the cache itself and address translation live elsewhere.

The entry count `ENTRIES` must be a power of two; all index arithmetic wraps modulo `ENTRIES`.

Top module: `lifo_entry_alloc`

## Requirements
- R1: After reset the top pointer is 0, every entry is invalid, and the fill and writeback masks are all zero.
- R2: An acquire without the extra flag marks entry `top` valid, advances the top by 1, and for one cycle drives `fill_mask_o` with only that entry's bit set.
- R3: An acquire with the extra flag marks entries `top` and `top+1` (modulo ENTRIES) valid, advances the top by 2, and drives both bits in `fill_mask_o` for one cycle.
- R4: In the same cycle as the request, `acc_idx_o` equals `(top - 1 - acc_ofs_i)` modulo ENTRIES, and `acc_hit_o` equals the valid bit of that entry.
- R5: `acc_to_cache_o` is 1 exactly when `acc_req_i` is 1 and the resolved entry is invalid; it is 0 whenever no access is requested.
- R6: A release with count C lowers the top by C modulo ENTRIES and clears the valid bits of the C entries just below the old top; a count of ENTRIES or more clears every entry.
- R7: Acquires beyond the physical entry count wrap the top around and reuse entry 0 onward.
- R8: On an acquire, `wb_mask_o` in the following cycle holds each claimed entry that was valid and marked dirty on `ent_dirty_i`, and `wb_req_o` is the OR of that mask.
- R9: A flush clears all valid bits in a single cycle and leaves the top pointer unchanged.
- R10: Commands in one cycle are ranked flush, then release, then acquire; a lower-ranked command raised together with a higher one has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush_i | input | 1 | Drop every claim (highest rank) |
| rel_i | input | 1 | Release command |
| rel_cnt_i | input | CNT_W | Number of entries to release |
| acq_i | input | 1 | Acquire command |
| acq_extra_i | input | 1 | Acquire claims two entries |
| ent_dirty_i | input | ENTRIES | Per-entry modified-data flags from the line storage |
| acc_req_i | input | 1 | An access targets the pool this cycle |
| acc_ofs_i | input | IDX_W | Entry offset carried by the access |
| acc_idx_o | output | IDX_W | Resolved physical entry |
| acc_hit_o | output | 1 | Resolved entry is valid |
| acc_to_cache_o | output | 1 | Access must go to the ordinary data cache |
| top_o | output | IDX_W | Current top pointer (next free slot) |
| valid_o | output | ENTRIES | Valid bit of every entry |
| fill_mask_o | output | ENTRIES | Entries claimed by the last-cycle acquire, to be filled |
| wb_mask_o | output | ENTRIES | Claimed entries whose old dirty data must be written back first |
| wb_req_o | output | 1 | Any writeback is needed |

## Verification
Access resolution is combinational over registered state, so `acc_idx_o`, `acc_hit_o` and `acc_to_cache_o` are due in the same cycle as the request and are sampled a nanosecond after the inputs settle, before the next edge. The top pointer, valid bits, fill mask and writeback mask all change on the one edge that captures a command and are sampled a nanosecond after that edge. Every scenario drives inputs on the falling edge and checks only at those two points, so each expected value is tied to a known edge.

// File: rtl/lifo_alloc_pkg.sv
package lifo_alloc_pkg;
  typedef enum logic [1:0] {
    CMD_NONE  = 2'd0,
    CMD_ACQ   = 2'd1,
    CMD_REL   = 2'd2,
    CMD_FLUSH = 2'd3
  } alloc_cmd_e;

  // Rank the raw command lines: flush, then release, then acquire.
  function automatic alloc_cmd_e rank_cmd(input logic flush, input logic rel,
                                          input logic acq);
    if (flush)    return CMD_FLUSH;
    else if (rel) return CMD_REL;
    else if (acq) return CMD_ACQ;
    else          return CMD_NONE;
  endfunction
endpackage

// File: rtl/lifo_top_ptr.sv
module lifo_top_ptr
  import lifo_alloc_pkg::*;
#(
  parameter int ENTRIES = 4,
  localparam int IDX_W = $clog2(ENTRIES),
  localparam int CNT_W = IDX_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  alloc_cmd_e       cmd,
  input  logic             extra,
  input  logic [CNT_W-1:0] rel_cnt,
  output logic [IDX_W-1:0] top
);
  logic [IDX_W-1:0] top_q, top_nxt;
  logic             top_en;

  always_comb begin
    top_en  = (cmd == CMD_ACQ) || (cmd == CMD_REL);
    top_nxt = top_q;
    case (cmd)
      CMD_ACQ: top_nxt = extra ? top_q + IDX_W'(2) : top_q + IDX_W'(1);
      CMD_REL: top_nxt = top_q - rel_cnt[IDX_W-1:0];
      default: top_nxt = top_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      top_q <= '0;
    else if (top_en) top_q <= top_nxt;
  end

  assign top = top_q;

  // R6
  rel_moves_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_REL) |=> (top_q == $past(top_q) - $past(rel_cnt[IDX_W-1:0])));

  // R9
  flush_keeps_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_FLUSH) |=> $stable(top_q));
endmodule

// File: rtl/lifo_valid_bits.sv
module lifo_valid_bits
  import lifo_alloc_pkg::*;
#(
  parameter int ENTRIES = 4,
  localparam int IDX_W = $clog2(ENTRIES),
  localparam int CNT_W = IDX_W + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  alloc_cmd_e         cmd,
  input  logic               extra,
  input  logic [IDX_W-1:0]   top,
  input  logic [CNT_W-1:0]   rel_cnt,
  output logic [ENTRIES-1:0] alloc_mask,
  output logic [ENTRIES-1:0] valid
);
  logic [ENTRIES-1:0] valid_q, valid_nxt, free_mask;
  logic [IDX_W-1:0]   top_plus1;

  assign top_plus1 = top + IDX_W'(1);

  for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
    localparam logic [IDX_W-1:0] SLOT = IDX_W'(i);
    logic [IDX_W-1:0] depth;
    // Distance below the top: 0 for the most recent claim.
    assign depth         = top - IDX_W'(1) - SLOT;
    assign free_mask[i]  = {1'b0, depth} < rel_cnt;
    assign alloc_mask[i] = (SLOT == top) || (extra && (SLOT == top_plus1));
  end

  always_comb begin
    case (cmd)
      CMD_FLUSH: valid_nxt = '0;
      CMD_REL:   valid_nxt = valid_q & ~free_mask;
      CMD_ACQ:   valid_nxt = valid_q | alloc_mask;
      default:   valid_nxt = valid_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                valid_q <= '0;
    else if (cmd != CMD_NONE)  valid_q <= valid_nxt;
  end

  assign valid = valid_q;

  // R9
  flush_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_FLUSH) |=> (valid_q == '0));

  // R2
  acq_sets_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_ACQ) |=> valid_q[$past(top)]);

  // R6
  rel_clears_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_REL && rel_cnt != '0) |=> !valid_q[$past(top) - IDX_W'(1)]);
endmodule

// File: rtl/lifo_resolver.sv
module lifo_resolver #(
  parameter int ENTRIES = 4,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  logic [IDX_W-1:0]   top,
  input  logic [ENTRIES-1:0] valid,
  input  logic               req,
  input  logic [IDX_W-1:0]   ofs,
  output logic [IDX_W-1:0]   idx,
  output logic               hit,
  output logic               to_cache
);
  always_comb begin
    idx      = top - IDX_W'(1) - ofs;
    hit      = valid[idx];
    to_cache = req && !hit;
  end
endmodule

// File: rtl/lifo_entry_alloc.sv
module lifo_entry_alloc
  import lifo_alloc_pkg::*;
#(
  parameter int ENTRIES = 4,
  localparam int IDX_W = $clog2(ENTRIES),
  localparam int CNT_W = IDX_W + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               flush_i,
  input  logic               rel_i,
  input  logic [CNT_W-1:0]   rel_cnt_i,
  input  logic               acq_i,
  input  logic               acq_extra_i,
  input  logic [ENTRIES-1:0] ent_dirty_i,
  input  logic               acc_req_i,
  input  logic [IDX_W-1:0]   acc_ofs_i,
  output logic [IDX_W-1:0]   acc_idx_o,
  output logic               acc_hit_o,
  output logic               acc_to_cache_o,
  output logic [IDX_W-1:0]   top_o,
  output logic [ENTRIES-1:0] valid_o,
  output logic [ENTRIES-1:0] fill_mask_o,
  output logic [ENTRIES-1:0] wb_mask_o,
  output logic               wb_req_o
);
  alloc_cmd_e         cmd;
  logic [IDX_W-1:0]   top;
  logic [ENTRIES-1:0] valid, alloc_mask;
  logic [ENTRIES-1:0] fill_q, fill_nxt, wb_q, wb_nxt;

  assign cmd = rank_cmd(flush_i, rel_i, acq_i);

  lifo_top_ptr #(.ENTRIES(ENTRIES)) u_ptr (
    .clk(clk), .rst_n(rst_n), .cmd(cmd), .extra(acq_extra_i),
    .rel_cnt(rel_cnt_i), .top(top)
  );

  lifo_valid_bits #(.ENTRIES(ENTRIES)) u_valid (
    .clk(clk), .rst_n(rst_n), .cmd(cmd), .extra(acq_extra_i), .top(top),
    .rel_cnt(rel_cnt_i), .alloc_mask(alloc_mask), .valid(valid)
  );

  lifo_resolver #(.ENTRIES(ENTRIES)) u_res (
    .top(top), .valid(valid), .req(acc_req_i), .ofs(acc_ofs_i),
    .idx(acc_idx_o), .hit(acc_hit_o), .to_cache(acc_to_cache_o)
  );

  // Overwrite detection: claimed slots that still hold a live dirty line.
  always_comb begin
    fill_nxt = '0;
    wb_nxt   = '0;
    if (cmd == CMD_ACQ) begin
      fill_nxt = alloc_mask;
      wb_nxt   = alloc_mask & valid & ent_dirty_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fill_q <= '0;
      wb_q   <= '0;
    end else begin
      fill_q <= fill_nxt;
      wb_q   <= wb_nxt;
    end
  end

  assign top_o       = top;
  assign valid_o     = valid;
  assign fill_mask_o = fill_q;
  assign wb_mask_o   = wb_q;
  assign wb_req_o    = |wb_q;

  // R8
  wb_within_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_q & ~fill_q) == '0);

  // R3
  fill_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(fill_q) <= 2);

  // R10
  fill_only_on_acq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_i || rel_i) |=> (fill_q == '0));

  // R5
  cache_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_to_cache_o |-> acc_req_i);
endmodule

// File: tb/lifo_entry_alloc_tb.sv
module lifo_entry_alloc_tb;
  localparam int ENTRIES = 4;
  localparam int IDX_W = 2;
  localparam int CNT_W = 3;

  logic               clk = 1'b0;
  logic               rst_n;
  logic               flush_i, rel_i, acq_i, acq_extra_i, acc_req_i;
  logic [CNT_W-1:0]   rel_cnt_i;
  logic [ENTRIES-1:0] ent_dirty_i;
  logic [IDX_W-1:0]   acc_ofs_i;
  logic [IDX_W-1:0]   acc_idx_o, top_o;
  logic               acc_hit_o, acc_to_cache_o, wb_req_o;
  logic [ENTRIES-1:0] valid_o, fill_mask_o, wb_mask_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  lifo_entry_alloc #(.ENTRIES(ENTRIES)) u_dut (
    .clk(clk), .rst_n(rst_n), .flush_i(flush_i), .rel_i(rel_i),
    .rel_cnt_i(rel_cnt_i), .acq_i(acq_i), .acq_extra_i(acq_extra_i),
    .ent_dirty_i(ent_dirty_i), .acc_req_i(acc_req_i), .acc_ofs_i(acc_ofs_i),
    .acc_idx_o(acc_idx_o), .acc_hit_o(acc_hit_o),
    .acc_to_cache_o(acc_to_cache_o), .top_o(top_o), .valid_o(valid_o),
    .fill_mask_o(fill_mask_o), .wb_mask_o(wb_mask_o), .wb_req_o(wb_req_o)
  );

  task automatic chk(input string tag, input logic [31:0] got,
                     input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic idle_inputs();
    flush_i = 0; rel_i = 0; acq_i = 0; acq_extra_i = 0; rel_cnt_i = '0;
    acc_req_i = 0; acc_ofs_i = '0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    idle_inputs();
    ent_dirty_i = '0;
    rst_n = 0;
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  // Raise command lines at the falling edge, sample 1 ns after the next rise.
  task automatic cmd(input logic fl, input logic rl, input logic [CNT_W-1:0] cnt,
                     input logic aq, input logic ex);
    @(negedge clk);
    flush_i = fl; rel_i = rl; rel_cnt_i = cnt; acq_i = aq; acq_extra_i = ex;
    @(posedge clk);
    #1;
    idle_inputs();
  endtask

  task automatic access(input logic [IDX_W-1:0] ofs, input string tag,
                        input logic [IDX_W-1:0] exp_idx, input logic exp_hit);
    @(negedge clk);
    acc_req_i = 1; acc_ofs_i = ofs;
    #1;
    chk({tag, " idx"}, 32'(acc_idx_o), 32'(exp_idx));
    chk({tag, " hit"}, 32'(acc_hit_o), 32'(exp_hit));
    chk({tag, " to_cache"}, 32'(acc_to_cache_o), 32'(!exp_hit));
    acc_req_i = 0;
    #1;
    chk({tag, " to_cache idle (R5)"}, 32'(acc_to_cache_o), 32'd0);
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 top", 32'(top_o), 0);
    chk("R1 valid", 32'(valid_o), 0);
    chk("R1 fill", 32'(fill_mask_o), 0);
    chk("R1 wb", 32'(wb_mask_o), 0);
    access(2'd0, "R5 empty", 2'd3, 1'b0);
  endtask

  task automatic t_acquire();
    do_reset();
    cmd(0, 0, 0, 1, 0);
    chk("R2 top", 32'(top_o), 1);
    chk("R2 valid", 32'(valid_o), 32'b0001);
    chk("R2 fill", 32'(fill_mask_o), 32'b0001);
    cmd(0, 0, 0, 1, 1);
    chk("R3 top", 32'(top_o), 3);
    chk("R3 valid", 32'(valid_o), 32'b0111);
    chk("R3 fill", 32'(fill_mask_o), 32'b0110);
    @(posedge clk); #1;
    chk("R2 fill one cycle", 32'(fill_mask_o), 0);
    access(2'd0, "R4 ofs0", 2'd2, 1'b1);
    access(2'd2, "R4 ofs2", 2'd0, 1'b1);
    access(2'd3, "R5 ofs3", 2'd3, 1'b0);
  endtask

  task automatic t_release();
    do_reset();
    cmd(0, 0, 0, 1, 1);
    cmd(0, 0, 0, 1, 0);
    cmd(0, 1, 3'd2, 0, 0);
    chk("R6 rel2 top", 32'(top_o), 1);
    chk("R6 rel2 valid", 32'(valid_o), 32'b0001);
    cmd(0, 1, 3'd0, 0, 0);
    chk("R6 rel0 top", 32'(top_o), 1);
    chk("R6 rel0 valid", 32'(valid_o), 32'b0001);
    cmd(0, 1, 3'd1, 0, 0);
    chk("R6 rel1 top", 32'(top_o), 0);
    chk("R6 rel1 valid", 32'(valid_o), 0);
  endtask

  task automatic t_wrap();
    do_reset();
    for (int k = 0; k < 4; k++) cmd(0, 0, 0, 1, 0);
    chk("R7 top wrapped", 32'(top_o), 0);
    chk("R7 valid all", 32'(valid_o), 32'b1111);
    ent_dirty_i = 4'b0000;
    cmd(0, 0, 0, 1, 0);
    chk("R8 clean overwrite wb", 32'(wb_mask_o), 0);
    chk("R8 clean overwrite req", 32'(wb_req_o), 0);
    chk("R7 reuse entry0", 32'(fill_mask_o), 32'b0001);
    ent_dirty_i = 4'b1101;
    cmd(0, 0, 0, 1, 1);
    chk("R3 wrap top", 32'(top_o), 3);
    chk("R8 fill", 32'(fill_mask_o), 32'b0110);
    chk("R8 wb", 32'(wb_mask_o), 32'b0100);
    chk("R8 req", 32'(wb_req_o), 1);
    ent_dirty_i = '0;
    cmd(0, 1, 3'd2, 0, 0);
    chk("R6 wrap valid", 32'(valid_o), 32'b1001);
    access(2'd1, "R4 wrap ofs1", 2'd3, 1'b1);
    cmd(0, 1, 3'd4, 0, 0);
    chk("R6 rel all valid", 32'(valid_o), 0);
    chk("R6 rel all top", 32'(top_o), 1);
  endtask

  task automatic t_flush_prio();
    do_reset();
    cmd(0, 0, 0, 1, 1);
    cmd(1, 0, 0, 0, 0);
    chk("R9 flush valid", 32'(valid_o), 0);
    chk("R9 flush top", 32'(top_o), 2);
    cmd(1, 1, 3'd1, 1, 0);
    chk("R10 flush wins valid", 32'(valid_o), 0);
    chk("R10 flush wins top", 32'(top_o), 2);
    chk("R10 flush wins fill", 32'(fill_mask_o), 0);
    cmd(0, 0, 0, 1, 0);
    cmd(0, 1, 3'd1, 1, 1);
    chk("R10 rel wins top", 32'(top_o), 2);
    chk("R10 rel wins valid", 32'(valid_o), 0);
    chk("R10 rel wins fill", 32'(fill_mask_o), 0);
  endtask

  initial begin
    rst_n = 0;
    ent_dirty_i = '0;
    idle_inputs();
    t_reset();
    t_acquire();
    t_release();
    t_wrap();
    t_flush_prio();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule